// File: doc/BRIEF.md
# Divided-Clock Alarm Timer with Count Snapshot

This block is a single general-purpose timer built around a 54-bit counter. The counter steps once per tick from a programmable clock divider, either upward or downward, and can be preset in one step from a 54-bit load value. A separate 54-bit alarm value is compared against the running count. On a match, the block records a raw interrupt status bit and disarms the alarm. If periodic mode is selected, it also reloads the counter from the preset value.

Software controls the block through a small word-addressed register bus with a single-cycle write strobe and a combinational read port. Because the count is wider than a bus word, it is never read live. A self-clearing request bit copies it into a pair of snapshot words, and the request bit reads as pending until the copy has happened. The interrupt output is the raw status bit gated by an enable bit. Writing one to the clear register clears the status bit.

Top module: `alarm_timer`

Register map (word addresses): 0 control, 1 preset low, 2 preset high, 3 preset strobe, 4 alarm low, 5 alarm high, 6 snapshot request, 7 snapshot low, 8 snapshot high, 9 raw status, 10 interrupt enable, 11 status clear. Control word fields: bit 0 run, bit 1 direction (1 = up), bit 2 periodic reload, bit 3 alarm armed, bits 31:16 divider. High words carry count bits 53:32 in their bits 21:0.

## Requirements
- R1: After reset every readable register reads 0 and the interrupt output is 0.
- R2: With run set and a divider field N of 3 or more, the counter changes by one every N clock cycles, starting N cycles after run is written. With run clear, the count holds its value.
- R3: A divider field of 0 gives one tick per 65536 cycles. Divider fields 1 and 2 both give one tick per 2 cycles.
- R4: Direction bit 1 counts up and direction bit 0 counts down, both modulo 2^54: up from all ones gives 0, and down from 0 gives all ones.
- R5: Writing 1 in bit 0 of the preset strobe register loads the full 54-bit preset value into the counter at that clock edge.
- R6: Writing 1 in bit 0 of the snapshot request register makes the request bit read 1 for one cycle. It then reads 0, and the snapshot words hold the count from the cycle after the request.
- R7: When run and armed are set and the count equals the alarm value, the raw status bit becomes 1 and the armed bit clears itself on the next edge.
- R8: With periodic reload set, the alarm match reloads the counter from the preset value on the next edge, after which counting resumes from there.
- R9: The interrupt output is 1 exactly when the raw status bit and the enable bit are both 1. Writing 1 in bit 0 of the clear register sets the raw bit to 0.
- R10: While armed is clear, a count equal to the alarm value leaves the raw status bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt (raw status and enable) |

## Verification
The divide-by-65536 setting is the hardest case to reach from the ports. The stimulus runs the timer for a little over 65536 cycles and then stops it, so that exactly one step is visible in the snapshot. Alarm self-disarm and periodic reload happen while the timer runs and are not directly visible. They are exposed by reading the control word while counting continues, and by the final stopped count, which differs by exactly the amount lost to the reload. Stopping the timer at a precisely chosen edge turns every timing claim into a single snapshot value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 54;
    localparam int WORD_W = 32;
    localparam int HI_W   = CNT_W - WORD_W;
    localparam int DIV_W  = 16;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 4'd0,
        A_LOAD_LO  = 4'd1,
        A_LOAD_HI  = 4'd2,
        A_LOAD_GO  = 4'd3,
        A_ALARM_LO = 4'd4,
        A_ALARM_HI = 4'd5,
        A_SNAP_REQ = 4'd6,
        A_SNAP_LO  = 4'd7,
        A_SNAP_HI  = 4'd8,
        A_IRQ_RAW  = 4'd9,
        A_IRQ_EN   = 4'd10,
        A_IRQ_CLR  = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             arm;
        logic             reload;
        logic             up;
        logic             run;
    } ctrl_t;

    // Effective divide ratio: 0 -> 2^DIV_W, 1 and 2 -> 2, else N.
    function automatic logic [DIV_W:0] div_ratio(input logic [DIV_W-1:0] d);
        if (d == '0)
            return {1'b1, {DIV_W{1'b0}}};
        else if (d <= 2)
            return (DIV_W+1)'(2);
        else
            return {1'b0, d};
    endfunction

    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic up);
        return up ? c + 1'b1 : c - 1'b1;
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW:0] pcnt;
    logic [DW:0] last;

    assign last = div_ratio(div) - 1'b1;
    assign tick = run && (pcnt >= last);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pcnt <= '0;
        else if (pcnt >= last)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load_go,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] alarm_val,
    input  ctrl_t        ctrl,
    output logic [W-1:0] count,
    output logic         hit
);
    assign hit = ctrl.run && ctrl.arm && (count == alarm_val);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load_go)
            count <= load_val;
        else if (hit && ctrl.reload)
            count <= load_val;
        else if (tick)
            count <= step(count, ctrl.up);
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              hit,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  alarm_val,
    output logic              load_go,
    output logic              raw,
    output logic              irq_en
);
    logic             pending;
    logic [CNT_W-1:0] snap;
    logic             wr_ctrl;
    logic             clr;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign load_go = bus_wr && (bus_addr == A_LOAD_GO) && bus_wdata[0];
    assign clr     = bus_wr && (bus_addr == A_IRQ_CLR) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            load_val  <= '0;
            alarm_val <= '0;
            irq_en    <= 1'b0;
            raw       <= 1'b0;
            pending   <= 1'b0;
            snap      <= '0;
        end else begin
            if (wr_ctrl)
                ctrl <= '{div: bus_wdata[31:16], arm: bus_wdata[3],
                          reload: bus_wdata[2], up: bus_wdata[1], run: bus_wdata[0]};
            else if (hit)
                ctrl.arm <= 1'b0;

            if (bus_wr && bus_addr == A_LOAD_LO)  load_val[WORD_W-1:0]      <= bus_wdata;
            if (bus_wr && bus_addr == A_LOAD_HI)  load_val[CNT_W-1:WORD_W]  <= bus_wdata[HI_W-1:0];
            if (bus_wr && bus_addr == A_ALARM_LO) alarm_val[WORD_W-1:0]     <= bus_wdata;
            if (bus_wr && bus_addr == A_ALARM_HI) alarm_val[CNT_W-1:WORD_W] <= bus_wdata[HI_W-1:0];
            if (bus_wr && bus_addr == A_IRQ_EN)   irq_en <= bus_wdata[0];

            if (hit)
                raw <= 1'b1;
            else if (clr)
                raw <= 1'b0;

            if (pending) begin
                snap    <= count;
                pending <= 1'b0;
            end else if (bus_wr && bus_addr == A_SNAP_REQ && bus_wdata[0]) begin
                pending <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:     bus_rdata = {ctrl.div, 12'd0, ctrl.arm, ctrl.reload, ctrl.up, ctrl.run};
            A_LOAD_LO:  bus_rdata = load_val[WORD_W-1:0];
            A_LOAD_HI:  bus_rdata = {{(WORD_W-HI_W){1'b0}}, load_val[CNT_W-1:WORD_W]};
            A_ALARM_LO: bus_rdata = alarm_val[WORD_W-1:0];
            A_ALARM_HI: bus_rdata = {{(WORD_W-HI_W){1'b0}}, alarm_val[CNT_W-1:WORD_W]};
            A_SNAP_REQ: bus_rdata = {{(WORD_W-1){1'b0}}, pending};
            A_SNAP_LO:  bus_rdata = snap[WORD_W-1:0];
            A_SNAP_HI:  bus_rdata = {{(WORD_W-HI_W){1'b0}}, snap[CNT_W-1:WORD_W]};
            A_IRQ_RAW:  bus_rdata = {{(WORD_W-1){1'b0}}, raw};
            A_IRQ_EN:   bus_rdata = {{(WORD_W-1){1'b0}}, irq_en};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/alarm_timer.sv
module alarm_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] alarm_val;
    logic [CNT_W-1:0] count;
    logic             load_go;
    logic             raw;
    logic             irq_en;
    logic             tick;
    logic             hit;

    tmr_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .hit(hit),
        .ctrl(ctrl), .load_val(load_val), .alarm_val(alarm_val),
        .load_go(load_go), .raw(raw), .irq_en(irq_en)
    );

    tmr_prescale #(.DW(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .run(ctrl.run), .div(ctrl.div), .tick(tick)
    );

    tmr_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .load_go(load_go),
        .load_val(load_val), .alarm_val(alarm_val), .ctrl(ctrl),
        .count(count), .hit(hit)
    );

    assign irq = raw && irq_en;
endmodule

// File: rtl/alarm_timer_chk.sv
module alarm_timer_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              hit,
    input logic              run,
    input logic              arm,
    input logic              reload,
    input logic              raw,
    input logic              load_go,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  load_val,
    input logic [WORD_W-1:0] bus_rdata
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    assert_arm_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && !ctrl_wr) |=> !arm);

    assert_raw_set_R7: assert property (@(posedge clk) disable iff (rst)
        hit |=> raw);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_go) |=> $stable(count));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        load_go |=> (count == $past(load_val)));

    assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (hit && reload && !load_go) |=> (count == $past(load_val)));

    assert_snap_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_SNAP_REQ && bus_rdata[0] && $stable(bus_addr)) |=>
            !(bus_addr == A_SNAP_REQ && bus_rdata[0] && $past(bus_rdata[0])));
endmodule

bind alarm_timer alarm_timer_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .hit(hit), .run(ctrl.run), .arm(ctrl.arm), .reload(ctrl.reload),
    .raw(raw), .load_go(load_go), .count(count), .load_val(load_val),
    .bus_rdata(bus_rdata)
);

// File: tb/alarm_timer_tb_top.sv
module alarm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [32:0] exp_q[$];
    string       tag_q[$];
    event        smp;

    always #2 clk = ~clk;

    alarm_timer dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: pops one expected item per sample event and compares.
    always @(smp) begin
        logic [32:0] e;
        string       t;
        logic [31:0] got;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = e[32] ? {31'd0, irq} : bus_rdata;
        n_cmp++;
        if (got !== e[31:0]) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", t, got, e[31:0]);
        end
    end

    function automatic logic [31:0] mk(bit run, bit up, bit rel, bit arm, int div);
        return {div[15:0], 12'd0, arm, rel, up, run};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] e, input string t);
        exp_q.push_back({1'b0, e}); tag_q.push_back(t);
        bus_addr = a;
        #1 -> smp;
        @(negedge clk);
    endtask

    task automatic chk_irq(input bit e, input string t);
        exp_q.push_back({1'b1, 31'd0, e}); tag_q.push_back(t);
        #1 -> smp;
        @(negedge clk);
    endtask

    task automatic preset(input logic [31:0] lo, input logic [31:0] hi);
        wr(4'd1, lo); wr(4'd2, hi); wr(4'd3, 32'd1);
    endtask

    task automatic snap(input logic [31:0] lo, input logic [31:0] hi, input string t);
        wr(4'd6, 32'd1);
        chk(4'd6, 32'd1, {t, " pending"});
        chk(4'd6, 32'd0, {t, " done"});
        chk(4'd7, lo, {t, " lo"});
        chk(4'd8, hi, {t, " hi"});
    endtask

    // Run for exactly n clock edges with ctrl word c, then stop.
    task automatic run_for(input logic [31:0] c, input int n);
        wr(4'd0, c);
        repeat (n - 1) @(negedge clk);
        wr(4'd0, {c[31:16], 14'd0, c[1], 1'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(4'd0, 32'd0, "R1 ctrl");
        chk(4'd9, 32'd0, "R1 raw");
        chk(4'd6, 32'd0, "R1 snap req");
        chk(4'd7, 32'd0, "R1 snap lo");
        chk_irq(1'b0, "R1 irq");

        // R5 full-width preset
        preset(32'h89AB_CDEF, 32'h0015_5555);
        snap(32'h89AB_CDEF, 32'h0015_5555, "R5 preset");

        // R2 divide by 4, then hold while stopped
        preset(32'd0, 32'd0);
        run_for(mk(1, 1, 0, 0, 4), 12);
        snap(32'd3, 32'd0, "R2 div4");
        repeat (10) @(negedge clk);
        snap(32'd3, 32'd0, "R2 hold");
        preset(32'd0, 32'd0);
        run_for(mk(1, 1, 0, 0, 5), 12);
        snap(32'd2, 32'd0, "R2 div5");

        // R3 divider encodings
        preset(32'd0, 32'd0);
        run_for(mk(1, 1, 0, 0, 1), 10);
        snap(32'd5, 32'd0, "R3 div1");
        preset(32'd0, 32'd0);
        run_for(mk(1, 1, 0, 0, 2), 10);
        snap(32'd5, 32'd0, "R3 div2");
        preset(32'd0, 32'd0);
        run_for(mk(1, 1, 0, 0, 0), 65540);
        snap(32'd1, 32'd0, "R3 div0");

        // R4 direction and wrap
        preset(32'd10, 32'd0);
        run_for(mk(1, 0, 0, 0, 1), 8);
        snap(32'd6, 32'd0, "R4 down");
        preset(32'hFFFF_FFFF, 32'h003F_FFFF);
        run_for(mk(1, 1, 0, 0, 2), 2);
        snap(32'd0, 32'd0, "R4 wrap up");
        preset(32'd0, 32'd0);
        run_for(mk(1, 0, 0, 0, 2), 2);
        snap(32'hFFFF_FFFF, 32'h003F_FFFF, "R4 wrap down");

        // R10 unarmed match does nothing
        wr(4'd4, 32'd3); wr(4'd5, 32'd0); wr(4'd10, 32'd1);
        preset(32'd0, 32'd0);
        run_for(mk(1, 1, 0, 0, 2), 20);
        chk(4'd9, 32'd0, "R10 raw");
        chk_irq(1'b0, "R10 irq");

        // R7 armed one-shot alarm
        preset(32'd0, 32'd0);
        wr(4'd0, mk(1, 1, 0, 1, 2));
        repeat (18) @(negedge clk);
        chk(4'd0, mk(1, 1, 0, 0, 2), "R7 arm cleared");
        wr(4'd0, mk(0, 1, 0, 0, 2));
        chk(4'd9, 32'd1, "R7 raw");
        chk_irq(1'b1, "R7 irq");
        snap(32'd10, 32'd0, "R7 no reload");

        // R9 enable gating and clear
        wr(4'd10, 32'd0);
        chk_irq(1'b0, "R9 gated");
        chk(4'd9, 32'd1, "R9 raw kept");
        wr(4'd10, 32'd1);
        chk_irq(1'b1, "R9 enabled");
        wr(4'd11, 32'd1);
        chk(4'd9, 32'd0, "R9 cleared");
        chk_irq(1'b0, "R9 irq low");

        // R8 periodic reload
        preset(32'd0, 32'd0);
        wr(4'd0, mk(1, 1, 1, 1, 2));
        repeat (18) @(negedge clk);
        chk(4'd0, mk(1, 1, 1, 0, 2), "R8 arm cleared");
        wr(4'd0, mk(0, 1, 0, 0, 2));
        snap(32'd7, 32'd0, "R8 reloaded");
        chk(4'd9, 32'd1, "R8 raw");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule